// File: doc/BRIEF.md
# Multi-Channel ADC Conversion Request Controller

This block decides when each of four ADC channels should ask the conversion sequencer for a new sample. Every channel latches a request flag. The flag is set when one of three trigger sources fires while the channel's gate allows it. The three sources are an edge on one of eight shared trigger lines, a periodic tick from the channel's own reload timer, and a pulse passed on from the previous channel in a ring.

The gate is built from one of eight shared gating lines through a small mode field. The same gate also decides whether the channel timer counts. Software-style strobes can set or clear each flag directly. A conversion-start pulse from the sequencer clears the flag. All configuration fields come in as plain per-channel inputs. The sequencer reads the flags.

Top module: `adc_req_ctrl`

## Requirements
- R1: During and directly after a synchronous reset, every request flag and every neighbour output is 0.
- R2: Each channel picks its trigger line with a 3-bit index into the 8-bit trigger bus. Lines that are not selected never set that channel's flag.
- R3: Edge mode per channel (2 bits) works as follows: 00 detects nothing, 01 detects a rising edge, 10 detects a falling edge, 11 detects both. An edge is the selected line's value differing from its value one clock earlier.
- R4: Gate mode per channel (2 bits) works as follows: 00 is always blocked, 01 is always open, 10 is open while the selected gating line is 1, 11 is open while it is 0. The gating line is picked with its own 3-bit index into the 8-bit gating bus.
- R5: A trigger that arrives while the gate is blocked leaves the flag unchanged.
- R6: The channel timer is a 10-bit down-counter. With a nonzero reload value R and an open gate, it ticks in the first open cycle and then every R+1 open cycles. It holds its count while the gate is blocked. A reload value of 0 stops it.
- R7: Neighbour output bit x is channel x's edge-or-timer trigger, delayed by one clock. Channel x takes neighbour output bit (x+3) mod 4 as its third trigger source.
- R8: A conversion-start pulse or a clear strobe clears the flag on the next clock. A set event in the same cycle wins over a clear.
- R9: The set strobe sets the flag on the next clock, whatever the gate and trigger state.
- R10: The four channels behave independently, apart from the neighbour ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 8 | Shared external trigger lines |
| gate_i | input | 8 | Shared gating lines |
| trig_sel_i | input | 12 | Trigger line index, 3 bits per channel |
| gate_sel_i | input | 12 | Gating line index, 3 bits per channel |
| trig_mode_i | input | 8 | Edge mode, 2 bits per channel |
| gate_mode_i | input | 8 | Gate mode, 2 bits per channel |
| reload_i | input | 40 | Timer reload value, 10 bits per channel |
| sw_set_i | input | 4 | Per-channel flag set strobe |
| sw_clr_i | input | 4 | Per-channel flag clear strobe |
| conv_start_i | input | 4 | Per-channel conversion-started pulse |
| req_o | output | 4 | Registered conversion request flags |
| nbr_o | output | 4 | Registered per-channel trigger passed to the next channel |

## Verification
The main function is driven in several ways.

- A single pulse on the selected line, together with a pulse on a neighbouring line, separates the selection logic from the edge logic.
- A pulse swept through all four edge modes separates rising, falling and both-edge detection.
- A pulse repeated under all gate modes with both gating-line levels separates level gating from the fixed modes.
- A long timer run that is gated off part way shows the difference between a counter that pauses and one that restarts.
- Set and clear strobes applied together expose the priority.
- A long stretch of random line levels, strobes and reconfigurations is checked against a cycle model. It catches interactions between channels, such as neighbour pulses combined with clears.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  typedef enum logic [1:0] {
    GATE_BLOCK = 2'b00,
    GATE_OPEN  = 2'b01,
    GATE_HIGH  = 2'b10,
    GATE_LOW   = 2'b11
  } gate_mode_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  function automatic logic gate_open(gate_mode_e mode, logic line);
    case (mode)
      GATE_BLOCK: return 1'b0;
      GATE_OPEN:  return 1'b1;
      GATE_HIGH:  return line;
      default:    return ~line;
    endcase
  endfunction

  function automatic logic edge_seen(edge_mode_e mode, logic now_v, logic old_v);
    case (mode)
      EDGE_NONE: return 1'b0;
      EDGE_RISE: return now_v & ~old_v;
      EDGE_FALL: return ~now_v & old_v;
      default:   return now_v ^ old_v;
    endcase
  endfunction

endpackage

// File: rtl/adc_src_pick.sv
module adc_src_pick
  import adc_trig_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int SELW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] trig_now_i,
  input  logic [NSRC-1:0] trig_old_i,
  input  logic [NSRC-1:0] gate_i,
  input  logic [SELW-1:0] trig_sel_i,
  input  logic [SELW-1:0] gate_sel_i,
  input  logic [1:0]      trig_mode_i,
  input  logic [1:0]      gate_mode_i,
  output logic            edge_o,
  output logic            open_o
);

  logic line_now;
  logic line_old;
  logic gate_line;

  always_comb begin
    line_now  = trig_now_i[trig_sel_i];
    line_old  = trig_old_i[trig_sel_i];
    gate_line = gate_i[gate_sel_i];
    edge_o    = edge_seen(edge_mode_e'(trig_mode_i), line_now, line_old);
    open_o    = gate_open(gate_mode_e'(gate_mode_i), gate_line);
  end

endmodule

// File: rtl/adc_chan_timer.sv
module adc_chan_timer #(
  parameter int TMRW = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run_i,
  input  logic [TMRW-1:0] reload_i,
  output logic            tick_o
);

  logic [TMRW-1:0] count_q;
  logic            armed;
  logic            at_zero;

  assign armed   = (reload_i != '0);
  assign at_zero = (count_q == '0);
  assign tick_o  = run_i & armed & at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (!armed) begin
      count_q <= '0;
    end else if (run_i) begin
      count_q <= at_zero ? reload_i : count_q - TMRW'(1);
    end
  end

endmodule

// File: rtl/adc_req_flag.sv
module adc_req_flag (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  input  logic open_i,
  input  logic sw_set_i,
  input  logic drop_i,
  output logic flag_o
);

  logic set_evt;

  assign set_evt = (fire_i & open_i) | sw_set_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
    end else if (set_evt) begin
      flag_o <= 1'b1;
    end else if (drop_i) begin
      flag_o <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_req_ctrl.sv
module adc_req_ctrl #(
  parameter  int NCH  = 4,
  parameter  int NSRC = 8,
  parameter  int TMRW = 10,
  localparam int SELW = $clog2(NSRC)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NSRC-1:0]     trig_i,
  input  logic [NSRC-1:0]     gate_i,
  input  logic [NCH*SELW-1:0] trig_sel_i,
  input  logic [NCH*SELW-1:0] gate_sel_i,
  input  logic [NCH*2-1:0]    trig_mode_i,
  input  logic [NCH*2-1:0]    gate_mode_i,
  input  logic [NCH*TMRW-1:0] reload_i,
  input  logic [NCH-1:0]      sw_set_i,
  input  logic [NCH-1:0]      sw_clr_i,
  input  logic [NCH-1:0]      conv_start_i,
  output logic [NCH-1:0]      req_o,
  output logic [NCH-1:0]      nbr_o
);

  logic [NSRC-1:0] trig_q;
  logic [NCH-1:0]  local_fire;
  logic [NCH-1:0]  nbr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q <= '0;
      nbr_q  <= '0;
    end else begin
      trig_q <= trig_i;
      nbr_q  <= local_fire;
    end
  end

  assign nbr_o = nbr_q;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    localparam int PREV = (ch + NCH - 1) % NCH;
    logic edge_hit;
    logic open;
    logic tick;
    logic fire;

    adc_src_pick #(.NSRC(NSRC)) u_pick (
      .trig_now_i  (trig_i),
      .trig_old_i  (trig_q),
      .gate_i      (gate_i),
      .trig_sel_i  (trig_sel_i[ch*SELW +: SELW]),
      .gate_sel_i  (gate_sel_i[ch*SELW +: SELW]),
      .trig_mode_i (trig_mode_i[ch*2 +: 2]),
      .gate_mode_i (gate_mode_i[ch*2 +: 2]),
      .edge_o      (edge_hit),
      .open_o      (open)
    );

    adc_chan_timer #(.TMRW(TMRW)) u_tmr (
      .clk      (clk),
      .rst      (rst),
      .run_i    (open),
      .reload_i (reload_i[ch*TMRW +: TMRW]),
      .tick_o   (tick)
    );

    assign local_fire[ch] = edge_hit | tick;
    assign fire           = local_fire[ch] | nbr_q[PREV];

    adc_req_flag u_flag (
      .clk      (clk),
      .rst      (rst),
      .fire_i   (fire),
      .open_i   (open),
      .sw_set_i (sw_set_i[ch]),
      .drop_i   (sw_clr_i[ch] | conv_start_i[ch]),
      .flag_o   (req_o[ch])
    );
  end

endmodule

// File: rtl/adc_req_ctrl_chk.sv
module adc_req_ctrl_chk #(
  parameter  int NCH  = 4,
  parameter  int NSRC = 8,
  parameter  int TMRW = 10,
  localparam int SELW = $clog2(NSRC)
) (
  input logic                clk,
  input logic                rst,
  input logic [NSRC-1:0]     trig_i,
  input logic [NSRC-1:0]     gate_i,
  input logic [NCH*SELW-1:0] trig_sel_i,
  input logic [NCH*SELW-1:0] gate_sel_i,
  input logic [NCH*2-1:0]    trig_mode_i,
  input logic [NCH*2-1:0]    gate_mode_i,
  input logic [NCH*TMRW-1:0] reload_i,
  input logic [NCH-1:0]      sw_set_i,
  input logic [NCH-1:0]      sw_clr_i,
  input logic [NCH-1:0]      conv_start_i,
  input logic [NCH-1:0]      req_o,
  input logic [NCH-1:0]      nbr_o
);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (req_o == '0 && nbr_o == '0));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
    localparam int PREV = (ch + NCH - 1) % NCH;

    a_r9_set_strobe: assert property (@(posedge clk) disable iff (rst)
      sw_set_i[ch] |=> req_o[ch]);

    a_r8_clear_when_blocked: assert property (@(posedge clk) disable iff (rst)
      (gate_mode_i[ch*2 +: 2] == 2'b00 && !sw_set_i[ch] &&
       (sw_clr_i[ch] || conv_start_i[ch])) |=> !req_o[ch]);

    a_r5_hold_when_blocked: assert property (@(posedge clk) disable iff (rst)
      (gate_mode_i[ch*2 +: 2] == 2'b00 && !sw_set_i[ch] &&
       !sw_clr_i[ch] && !conv_start_i[ch]) |=> $stable(req_o[ch]));

    a_r7_ring_sets: assert property (@(posedge clk) disable iff (rst)
      (nbr_o[PREV] && gate_mode_i[ch*2 +: 2] == 2'b01) |=> req_o[ch]);

    a_r6_quiet_source: assert property (@(posedge clk) disable iff (rst)
      (trig_mode_i[ch*2 +: 2] == 2'b00 && reload_i[ch*TMRW +: TMRW] == '0)
        |=> !nbr_o[ch]);
  end

endmodule

bind adc_req_ctrl adc_req_ctrl_chk #(.NCH(NCH), .NSRC(NSRC), .TMRW(TMRW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .trig_i       (trig_i),
  .gate_i       (gate_i),
  .trig_sel_i   (trig_sel_i),
  .gate_sel_i   (gate_sel_i),
  .trig_mode_i  (trig_mode_i),
  .gate_mode_i  (gate_mode_i),
  .reload_i     (reload_i),
  .sw_set_i     (sw_set_i),
  .sw_clr_i     (sw_clr_i),
  .conv_start_i (conv_start_i),
  .req_o        (req_o),
  .nbr_o        (nbr_o)
);

// File: tb/tb_adc_req_ctrl.sv
module tb_adc_req_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 4;
  localparam int NSRC = 8;
  localparam int SELW = 3;
  localparam int TMRW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NSRC-1:0] trg = '0;
  logic [NSRC-1:0] gte = '0;
  logic [SELW-1:0] tsel [NCH];
  logic [SELW-1:0] gsel [NCH];
  logic [1:0]      tmode [NCH];
  logic [1:0]      gmode [NCH];
  logic [TMRW-1:0] rld [NCH];
  logic [NCH-1:0]  sset = '0, sclr = '0, cstart = '0;

  logic [NCH*SELW-1:0] tsel_p, gsel_p;
  logic [NCH*2-1:0]    tmode_p, gmode_p;
  logic [NCH*TMRW-1:0] rld_p;
  logic [NCH-1:0]      req, nbr;

  for (genvar g = 0; g < NCH; g++) begin : g_pack
    assign tsel_p[g*SELW +: SELW]  = tsel[g];
    assign gsel_p[g*SELW +: SELW]  = gsel[g];
    assign tmode_p[g*2 +: 2]       = tmode[g];
    assign gmode_p[g*2 +: 2]       = gmode[g];
    assign rld_p[g*TMRW +: TMRW]   = rld[g];
  end

  adc_req_ctrl #(.NCH(NCH), .NSRC(NSRC), .TMRW(TMRW)) dut (
    .clk(clk), .rst(rst), .trig_i(trg), .gate_i(gte),
    .trig_sel_i(tsel_p), .gate_sel_i(gsel_p),
    .trig_mode_i(tmode_p), .gate_mode_i(gmode_p), .reload_i(rld_p),
    .sw_set_i(sset), .sw_clr_i(sclr), .conv_start_i(cstart),
    .req_o(req), .nbr_o(nbr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int            cyc;
    logic [NCH-1:0] flags;
    logic [NCH-1:0] nb;
    string         tag;
  } exp_t;
  exp_t sbq[$];

  // reference state, built from the requirements
  logic [NSRC-1:0] m_prev = '0;
  int              m_cnt [NCH];
  logic [NCH-1:0]  m_flag = '0;
  logic [NCH-1:0]  m_nbr  = '0;

  task automatic push(string tag);
    exp_t e;
    e.cyc = cyc + 1; e.flags = m_flag; e.nb = m_nbr; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic model_step(string tag);
    logic [NCH-1:0] nf, nn;
    for (int ch = 0; ch < NCH; ch++) begin
      logic c, p, ed, g, en, tk, loc, anyv;
      int rv;
      c = trg[tsel[ch]];
      p = m_prev[tsel[ch]];
      case (tmode[ch])
        2'b00: ed = 1'b0;
        2'b01: ed = c && !p;
        2'b10: ed = !c && p;
        default: ed = (c != p);
      endcase
      g = gte[gsel[ch]];
      case (gmode[ch])
        2'b00: en = 1'b0;
        2'b01: en = 1'b1;
        2'b10: en = g;
        default: en = !g;
      endcase
      rv = int'(rld[ch]);
      tk = en && rv != 0 && m_cnt[ch] == 0;
      if (rv == 0) m_cnt[ch] = 0;
      else if (en) m_cnt[ch] = (m_cnt[ch] == 0) ? rv : m_cnt[ch] - 1;
      loc  = ed || tk;
      anyv = loc || m_nbr[(ch + NCH - 1) % NCH];
      if ((anyv && en) || sset[ch]) nf[ch] = 1'b1;
      else if (sclr[ch] || cstart[ch]) nf[ch] = 1'b0;
      else nf[ch] = m_flag[ch];
      nn[ch] = loc;
    end
    m_flag = nf;
    m_nbr  = nn;
    m_prev = trg;
    push(tag);
  endtask

  task automatic cycle(string tag);
    model_step(tag);
    @(negedge clk);
    sset = '0; sclr = '0; cstart = '0;
  endtask

  always @(negedge clk) begin
    exp_t e;
    while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
      e = sbq.pop_front();
      n_run++;
      if (req !== e.flags) begin
        n_fail++;
        $display("FAIL %s cyc %0d flags: actual %b expected %b", e.tag, cyc, req, e.flags);
      end
      n_run++;
      if (nbr !== e.nb) begin
        n_fail++;
        $display("FAIL %s cyc %0d neighbour: actual %b expected %b", e.tag, cyc, nbr, e.nb);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired at cyc %0d", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      tsel[i] = '0; gsel[i] = '0; tmode[i] = 2'b00; gmode[i] = 2'b00;
      rld[i] = '0; m_cnt[i] = 0;
    end
    repeat (3) @(negedge clk);
    push("R1 reset state");
    @(negedge clk);
    rst = 1'b0;

    // R2 / R3 / R7 / R8: selected rising edge on ch0, ring into ch1
    for (int i = 0; i < NCH; i++) gmode[i] = 2'b01;
    tsel[0] = 3'd5; tmode[0] = 2'b01;
    cycle("R2 idle");
    trg[5] = 1'b1; cycle("R2 R3 rising edge sets ch0");
    cycle("R7 ch1 set by neighbour");
    trg[5] = 1'b0; cstart = 4'b0011; cycle("R8 conversion start clears");
    trg[4] = 1'b1; cycle("R2 unselected line ignored");
    trg[4] = 1'b0; cycle("R2 unselected line ignored");

    // R3: edge mode sweep on ch1
    tsel[1] = 3'd3;
    for (int m = 0; m < 4; m++) begin
      tmode[1] = m[1:0];
      trg[3] = 1'b1; cycle("R3 edge mode rise phase");
      trg[3] = 1'b0; cycle("R3 edge mode fall phase");
      cstart = '1; cycle("R3 edge mode clear");
    end
    tmode[1] = 2'b00;

    // R4 / R5: gating sweep on ch2
    gsel[2] = 3'd6; tsel[2] = 3'd2; tmode[2] = 2'b01;
    for (int gm = 0; gm < 4; gm++) begin
      for (int gv = 0; gv < 2; gv++) begin
        gmode[2] = gm[1:0]; gte[6] = gv[0];
        trg[2] = 1'b1; cycle("R4 R5 gating mode");
        trg[2] = 1'b0; cycle("R4 R5 gating mode");
        cstart = '1; cycle("R4 clear");
      end
    end
    gmode[2] = 2'b01; tmode[2] = 2'b00; gte = '0;

    // R6: timer on ch3
    rld[3] = 10'd3;
    repeat (12) cycle("R6 timer period");
    gmode[3] = 2'b00;
    repeat (5) cycle("R6 timer held while blocked");
    gmode[3] = 2'b01;
    repeat (6) cycle("R6 timer resumes");
    rld[3] = '0;
    repeat (4) cycle("R6 reload zero stops");
    cstart = '1; cycle("R8 clear all");

    // R8 / R9: strobes with gates blocked
    for (int i = 0; i < NCH; i++) gmode[i] = 2'b00;
    sset[1] = 1'b1; cycle("R9 set while blocked");
    sset[1] = 1'b1; sclr[1] = 1'b1; cycle("R8 set beats clear");
    sclr[1] = 1'b1; cycle("R8 clear strobe");
    sset[2] = 1'b1; cstart[2] = 1'b1; cycle("R8 set beats conversion start");
    cstart[2] = 1'b1; cycle("R8 conversion start clears");

    // R10: simultaneous independent channels
    for (int i = 0; i < NCH; i++) begin
      gmode[i] = 2'b01; tsel[i] = i[2:0]; tmode[i] = 2'b01;
    end
    trg = 8'b0000_0101; cycle("R10 independent channels");
    trg = 8'b0000_1111; cycle("R10 independent channels");
    cycle("R10 independent channels");
    cstart = '1; cycle("R10 clear");

    // R10: mixed random traffic against the model
    for (int k = 0; k < 600; k++) begin
      trg = NSRC'($urandom); gte = NSRC'($urandom);
      if ((k % 20) == 0) begin
        for (int i = 0; i < NCH; i++) begin
          tsel[i] = SELW'($urandom); gsel[i] = SELW'($urandom);
          tmode[i] = 2'($urandom); gmode[i] = 2'($urandom);
          rld[i] = TMRW'($urandom % 6);
        end
      end
      sset   = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
      sclr   = NCH'($urandom) & NCH'($urandom);
      cstart = NCH'($urandom) & NCH'($urandom);
      cycle("R10 mixed traffic");
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule